// File: doc/BRIEF.md
# Prescaled Free-Running Tick Timer

This block is a register-mapped up-counter for a system timebase. Software picks one of three tick sources: a peripheral-clock strobe, a low-frequency strobe, or a fast oscillator strobe. The selected ticks pass through a divider chain, and each divided tick advances a counter that software can read. The oscillator source has its own divider in front of the main divider, and a control bit gates it. Each source arrives as a one-cycle enable strobe that is synchronous to the bus clock, so the whole block runs on a single clock.

Software accesses the block over a plain word-addressed bus. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. The block carries no data stream, so there is no valid/ready handshake. Every pin is plain control or status.

A status flag records a counter rollover, and writing a one to the flag clears it. A control bit triggers a soft reset: it returns all state to its reset values, reads back as one for exactly one cycle, and then clears itself.

Top module: `tick_timer`

## Requirements
- R1: After `rst_n` is released, the control, divider, status and count words all read 0.
- R2: The word address map is: control at 0, divider at 1, status at 2, count at 9. Any other address reads 0 and ignores writes. Control reads back only bits 0, 6 to 10 and 15. The divider word reads back only bits 15:0.
- R3: Control bit 0 (run) must be 1 for the count to advance. While it is 0, the count holds.
- R4: Control bits 8:6 choose the source. Code 1 takes `tick_periph`, code 4 takes `tick_slow` and code 5 takes `tick_osc`. Any other code gives no count. Strobes on unselected inputs have no effect.
- R5: With code 5, `tick_osc` reaches the dividers only while control bit 10 (oscillator gate) is 1.
- R6: Divider bits 15:12 hold a value v that divides oscillator ticks by v+1. The main divider follows this stage.
- R7: Divider bits 11:0 hold a value m that divides the selected ticks by m+1. With m = 0, every selected tick counts.
- R8: Writes to the count word have no effect on the count.
- R9: When the count wraps from all ones to zero, status bit 5 becomes 1. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R10: Writing control with bit 15 = 1 clears the count, the flag, both divider phases and all register fields. Control then reads 0x8000 for one cycle and 0 after that.
- R11: A write to the divider word, or a control write that changes the source code, restarts both divider phases. The next count then needs a full divided period.
- R12: Control bit 9 (mode) is stored and reads back. With mode 0 the count still wraps and runs freely, the same as with mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe, takes effect on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_periph | input | 1 | Peripheral-clock tick strobe |
| tick_slow | input | 1 | Low-frequency tick strobe |
| tick_osc | input | 1 | Oscillator tick strobe |

## Verification
The bench builds the block with `CNT_W = 8`. This places the all-ones-to-zero wrap, and with it the rollover flag set and clear rules, 256 ticks away instead of four billion. The divider fields keep their full widths. Small divider values make the divide-by-(v+1) boundaries, the pass-through at zero, and the phase restart on divider or source writes visible within tens of cycles.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W     = 32;
  localparam int MAIN_W     = 12;
  localparam int OSC_W      = 4;
  localparam int ADR_CTRL   = 0;
  localparam int ADR_DIV    = 1;
  localparam int ADR_STAT   = 2;
  localparam int ADR_COUNT  = 9;
  localparam int B_RUN      = 0;
  localparam int B_SRC_LO   = 6;
  localparam int B_MODE     = 9;
  localparam int B_OSCGATE  = 10;
  localparam int B_SOFTRST  = 15;
  localparam int B_ROLL     = 5;
  localparam int B_OSCDIV   = 12;
  localparam logic [2:0] SRC_PERIPH = 3'd1;
  localparam logic [2:0] SRC_SLOW   = 3'd4;
  localparam logic [2:0] SRC_OSC    = 3'd5;

  typedef struct packed {
    logic       osc_gate;
    logic       mode;
    logic [2:0] src;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/timer_div.sv
module timer_div #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             in_i,
  output logic             out_o
);
  logic [DIV_W-1:0] phase_q;
  logic             last;

  assign last  = (phase_q == div_i);
  assign out_o = in_i && last && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (clr_i)    phase_q <= '0;
    else if (in_i)     phase_q <= last ? '0 : phase_q + 1'b1;
  end

  assert_out_needs_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_o |-> in_i);
  assert_clr_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (phase_q == '0));
endmodule

// File: rtl/timer_count.sv
module timer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = step_i && !clr_i && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assert_hold_without_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(cnt_q));
  assert_wrap_to_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wrap_i,
  output ctrl_t             ctrl_o,
  output logic [MAIN_W-1:0] main_div_o,
  output logic [OSC_W-1:0]  osc_div_o,
  output logic              roll_o,
  output logic              swr_pend_o,
  output logic              sreset_o,
  output logic              phase_clr_o
);
  ctrl_t             ctrl_q;
  logic [MAIN_W-1:0] main_q;
  logic [OSC_W-1:0]  osc_q;
  logic              roll_q, pend_q;
  logic              wr_ctrl, wr_div, wr_stat;
  ctrl_t             ctrl_new;

  assign wr_ctrl = we_i && (addr_i == ADDR_W'(ADR_CTRL));
  assign wr_div  = we_i && (addr_i == ADDR_W'(ADR_DIV));
  assign wr_stat = we_i && (addr_i == ADDR_W'(ADR_STAT));

  assign ctrl_new.osc_gate = wdata_i[B_OSCGATE];
  assign ctrl_new.mode     = wdata_i[B_MODE];
  assign ctrl_new.src      = wdata_i[B_SRC_LO +: 3];
  assign ctrl_new.run      = wdata_i[B_RUN];

  assign sreset_o    = wr_ctrl && wdata_i[B_SOFTRST];
  assign phase_clr_o = sreset_o || wr_div || (wr_ctrl && (ctrl_new.src != ctrl_q.src));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      main_q <= '0;
      osc_q  <= '0;
      roll_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (sreset_o) begin
      ctrl_q <= '0;
      main_q <= '0;
      osc_q  <= '0;
      roll_q <= 1'b0;
      pend_q <= 1'b1;
    end else begin
      pend_q <= 1'b0;
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (wr_div) begin
        main_q <= wdata_i[MAIN_W-1:0];
        osc_q  <= wdata_i[B_OSCDIV +: OSC_W];
      end
      if (wrap_i)                        roll_q <= 1'b1;
      else if (wr_stat && wdata_i[B_ROLL]) roll_q <= 1'b0;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign main_div_o = main_q;
  assign osc_div_o  = osc_q;
  assign roll_o     = roll_q;
  assign swr_pend_o = pend_q;

  assert_softrst_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);
  assert_wrap_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && !sreset_o) |=> roll_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_periph,
  input  logic              tick_slow,
  input  logic              tick_osc
);
  ctrl_t             ctrl;
  logic [MAIN_W-1:0] main_div;
  logic [OSC_W-1:0]  osc_div;
  logic              roll, swr_pend, sreset, phase_clr;
  logic              osc_in, osc_out, main_in, step, wrap;
  logic [CNT_W-1:0]  cnt;

  timer_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .addr_i(bus_addr), .we_i(bus_we), .wdata_i(bus_wdata),
    .wrap_i(wrap), .ctrl_o(ctrl), .main_div_o(main_div), .osc_div_o(osc_div),
    .roll_o(roll), .swr_pend_o(swr_pend), .sreset_o(sreset), .phase_clr_o(phase_clr)
  );

  assign osc_in = ctrl.run && (ctrl.src == SRC_OSC) && ctrl.osc_gate && tick_osc;

  timer_div #(.DIV_W(OSC_W)) u_osc_div (
    .clk, .rst_n, .clr_i(phase_clr), .div_i(osc_div), .in_i(osc_in), .out_o(osc_out)
  );

  always_comb begin
    main_in = 1'b0;
    if (ctrl.run) begin
      case (ctrl.src)
        SRC_PERIPH: main_in = tick_periph;
        SRC_SLOW:   main_in = tick_slow;
        SRC_OSC:    main_in = osc_out;
        default:    main_in = 1'b0;
      endcase
    end
  end

  timer_div #(.DIV_W(MAIN_W)) u_main_div (
    .clk, .rst_n, .clr_i(phase_clr), .div_i(main_div), .in_i(main_in), .out_o(step)
  );

  timer_count #(.CNT_W(CNT_W)) u_count (
    .clk, .rst_n, .clr_i(sreset), .step_i(step), .cnt_o(cnt), .wrap_o(wrap)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(ADR_CTRL): begin
        bus_rdata[B_SOFTRST]    = swr_pend;
        bus_rdata[B_OSCGATE]    = ctrl.osc_gate;
        bus_rdata[B_MODE]       = ctrl.mode;
        bus_rdata[B_SRC_LO +: 3] = ctrl.src;
        bus_rdata[B_RUN]        = ctrl.run;
      end
      ADDR_W'(ADR_DIV): begin
        bus_rdata[MAIN_W-1:0]         = main_div;
        bus_rdata[B_OSCDIV +: OSC_W]  = osc_div;
      end
      ADDR_W'(ADR_STAT):  bus_rdata[B_ROLL] = roll;
      ADDR_W'(ADR_COUNT): bus_rdata[CNT_W-1:0] = cnt;
      default: bus_rdata = '0;
    endcase
  end

  assert_stopped_no_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.src != SRC_PERIPH && ctrl.src != SRC_SLOW && ctrl.src != SRC_OSC) |-> !step);
  assert_gate_blocks_osc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.src == SRC_OSC && !ctrl.osc_gate) |-> !osc_out);
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  localparam int CNT_W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_periph = 1'b0, tick_slow = 1'b0, tick_osc = 1'b0;
  int          errors = 0, checks = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer #(.CNT_W(CNT_W), .ADDR_W(4)) u_dut (
    .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .tick_periph, .tick_slow, .tick_osc
  );

  typedef struct packed {
    logic [15:0] ctrl;
    logic [15:0] div;
    logic [2:0]  mask;   // [2] osc, [1] slow, [0] periph
    logic [7:0]  cyc;
    logic [7:0]  expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0041, 16'h0000, 3'b001, 8'd10, 8'd10, 4'd4},  // R4 periph source
    '{16'h0101, 16'h0000, 3'b010, 8'd10, 8'd10, 4'd4},  // R4 slow source
    '{16'h0101, 16'h0000, 3'b001, 8'd10, 8'd0,  4'd4},  // R4 unselected input
    '{16'h0541, 16'h7000, 3'b100, 8'd40, 8'd5,  4'd6},  // R6 osc /8
    '{16'h0141, 16'h0000, 3'b100, 8'd40, 8'd0,  4'd5},  // R5 gate closed
    '{16'h0040, 16'h0000, 3'b001, 8'd10, 8'd0,  4'd3},  // R3 run off
    '{16'h01C1, 16'h0000, 3'b111, 8'd10, 8'd0,  4'd4},  // R4 stop code
    '{16'h0041, 16'h0002, 3'b001, 8'd12, 8'd4,  4'd7},  // R7 main /3
    '{16'h0541, 16'h1001, 3'b100, 8'd20, 8'd5,  4'd6},  // R6 osc /2 then main /2
    '{16'h0241, 16'h0000, 3'b001, 8'd7,  8'd7,  4'd12}, // R12 mode bit set
    '{16'h0541, 16'h0000, 3'b011, 8'd10, 8'd0,  4'd4}   // R4 osc code ignores others
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(input logic [2:0] m, input int n);
    tick_periph = m[0]; tick_slow = m[1]; tick_osc = m[2];
    repeat (n) @(negedge clk);
    tick_periph = 1'b0; tick_slow = 1'b0; tick_osc = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(4'd0, d); check("R1 ctrl", d, 0);
    rd(4'd1, d); check("R1 div", d, 0);
    rd(4'd2, d); check("R1 status", d, 0);
    rd(4'd9, d); check("R1 count", d, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(4'd0, 32'h8000);
      wr(4'd1, {16'h0, VECS[i].div});
      wr(4'd0, {16'h0, VECS[i].ctrl});
      ticks(VECS[i].mask, int'(VECS[i].cyc));
      rd(4'd9, d);
      checks++;
      if (d !== {24'h0, VECS[i].expv}) begin
        errors++;
        $display("FAIL R%0d row %0d: actual=%0d expected=%0d", VECS[i].req, i, d, VECS[i].expv);
      end
    end

    // R2 address map and readback masks
    wr(4'd0, 32'h8000);
    wr(4'd1, 32'hFFFF_ABCD);
    rd(4'd1, d); check("R2 div readback", d, 32'h0000_ABCD);
    wr(4'd0, 32'hFFFF_7FFF);
    rd(4'd0, d); check("R2 ctrl mask", d, 32'h0000_07C1);
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, d); check("R2 unused word", d, 0);
    rd(4'd3, d); check("R2 unused word 3", d, 0);
    rd(4'd8, d); check("R2 unused word 8", d, 0);

    // R8 count write ignored
    wr(4'd0, 32'h8000);
    wr(4'd0, 32'h41);
    ticks(3'b001, 3);
    wr(4'd9, 32'h55);
    rd(4'd9, d); check("R8 count write", d, 3);

    // R11 phase restart on divider write
    wr(4'd0, 32'h8000);
    wr(4'd1, 32'h3);
    wr(4'd0, 32'h41);
    ticks(3'b001, 5);
    rd(4'd9, d); check("R11 before restart", d, 1);
    wr(4'd1, 32'h3);
    ticks(3'b001, 3);
    rd(4'd9, d); check("R11 after restart", d, 1);
    ticks(3'b001, 1);
    rd(4'd9, d); check("R11 full period", d, 2);
    // R11 source change restarts phase
    ticks(3'b011, 2);
    wr(4'd0, 32'h101);
    ticks(3'b011, 3);
    rd(4'd9, d); check("R11 source change", d, 2);
    ticks(3'b011, 1);
    rd(4'd9, d); check("R11 source full period", d, 3);

    // R9 wrap and rollover flag; R12 mode 0 still wraps
    wr(4'd0, 32'h8000);
    wr(4'd0, 32'h41);
    ticks(3'b001, 255);
    rd(4'd9, d); check("R9 count at max", d, 255);
    rd(4'd2, d); check("R9 flag before wrap", d, 0);
    ticks(3'b001, 1);
    rd(4'd9, d); check("R12 wrap to zero", d, 0);
    rd(4'd2, d); check("R9 flag set", d, 32'h20);
    wr(4'd2, 32'h0);
    rd(4'd2, d); check("R9 write 0 keeps", d, 32'h20);
    wr(4'd2, 32'h20);
    rd(4'd2, d); check("R9 write 1 clears", d, 0);

    // R10 soft reset
    wr(4'd1, 32'h0123);
    ticks(3'b001, 2);
    wr(4'd2, 32'h0);
    ticks(3'b000, 0);
    // create the flag again: count is 0 with divider /0x124, so force wrap quickly
    wr(4'd1, 32'h0);
    ticks(3'b001, 256);
    rd(4'd2, d); check("R9 flag second wrap", d, 32'h20);
    bus_addr = 4'd0; bus_wdata = 32'h8000;
    @(negedge clk); bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(4'd0, d); check("R10 pending reads one", d, 32'h8000);
    @(negedge clk);
    rd(4'd0, d); check("R10 self clears", d, 0);
    rd(4'd9, d); check("R10 count cleared", d, 0);
    rd(4'd2, d); check("R10 flag cleared", d, 0);
    rd(4'd1, d); check("R10 divider cleared", d, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule